// File: doc/BRIEF.md
# I2C Bus Wedge Fault Injector

This block is a stimulus controller for bus-robustness testing. It acts as an I2C master that deliberately stops in the middle of a transaction. The bus is left with SCL released high and SDA released. Slave devices and bus-recovery logic can then be checked against a bus that is stuck in a known position.

A single command picks a wedge mode and supplies a 7-bit target address, a register byte and a bit count. The block then drives start conditions and data bits through open-drain enables, using the same start, transmit-bit and receive-bit primitives as an ordinary master. It halts at the chosen point, lets SCL float high and waits for it to rise, honouring clock stretching up to a timeout. It then reports the synchronised SDA and SCL levels it saw on entering the hold.

A stop condition is never issued. The hold is left only through the release input or a synchronous reset.

Top module: `i2c_wedge_injector`

## Requirements
- R1: Mode code 0 (acknowledge wedge) issues a start, then the address byte {addr, 0} most significant bit first, as exactly 8 SCL pulses. The next SCL rise is the hold, with SDA released and no acknowledge pulse clocked.
- R2: Mode code 2 (write wedge) issues a start, the byte {addr, 0}, and one acknowledge slot with SDA released. It then sends the top N bits of the register byte, most significant first, followed by the hold rise with SDA released.
- R3: Mode code 1 (read wedge) issues a start, {addr, 0}, an acknowledge slot, the register byte and an acknowledge slot. It then issues a repeated start (SCL rises with SDA high, then SDA falls) and sends {addr, 1} and an acknowledge slot. After that it clocks N receive slots with SDA released, whose data is discarded, and then the hold rise.
- R4: In the hold state `holding` is 1 and both open-drain enables are 0. SDA is never released while SCL is released, so no stop condition ever appears.
- R5: On entering the hold, `held_sda` and `held_scl` capture the synchronised line levels. They stay constant for as long as the hold lasts.
- R6: A command is rejected in any of three cases: mode code 3, a write wedge with N > 8, or a read wedge with N > 9. A rejected command sets `err_range`, causes no bus activity and leaves the block idle. The next accepted command clears `err_range`.
- R7: While holding, new commands are ignored and the bus is untouched. A one-cycle `bus_release` pulse returns the block to idle without any bus edge.
- R8: If SCL has not gone high within TMO_CYC cycles of being released for the hold, `stretch_to` is set. The hold is still entered, with both enables 0 and `held_scl` = 0. The next accepted command clears `stretch_to`.
- R9: A bit count of 0 in write or read wedge mode goes straight from the last acknowledge slot to the hold rise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | One-cycle command strobe, taken only when idle |
| cmd_mode | input | 2 | 0 acknowledge wedge, 1 read wedge, 2 write wedge, 3 invalid |
| cmd_addr | input | 7 | Target address |
| cmd_reg | input | 8 | Register byte |
| cmd_bits | input | 4 | Bit count N for the tail of the sequence |
| bus_release | input | 1 | Leaves the hold state |
| scl_in | input | 1 | SCL line level |
| sda_in | input | 1 | SDA line level |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |
| busy | output | 1 | Sequence in progress |
| holding | output | 1 | Hold state reached |
| err_range | output | 1 | Last command rejected |
| stretch_to | output | 1 | SCL did not rise in time during a wait |
| held_sda | output | 1 | SDA level captured on entering the hold |
| held_scl | output | 1 | SCL level captured on entering the hold |

## Verification
A wrong phase or index in the sequencer shows up on the bus itself. It appears as a missing or extra SCL pulse, a wrong bit value at an SCL rise, or a start in the wrong place, and the bus monitor reports it at the first wrong edge, within a few setup intervals. A wrong hold or release state shows at once on `holding` or on the enables. A bad capture or flag shows on `held_*`, `err_range` or `stretch_to` in the cycle the hold is reached or the command is refused.

// File: rtl/i2cw_pkg.sv
package i2cw_pkg;
  typedef enum logic [1:0] {OP_START, OP_WR, OP_RD, OP_HOLD} op_e;
  localparam logic [1:0] MODE_ACK   = 2'd0;
  localparam logic [1:0] MODE_READ  = 2'd1;
  localparam logic [1:0] MODE_WRITE = 2'd2;
  localparam int ADDR_W = 7;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = 4;
endpackage

// File: rtl/i2cw_sync.sv
module i2cw_sync #(
  parameter int WIDTH = 2,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [STAGES-1:0][WIDTH-1:0] r;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) r[s] <= RST_VAL;
        else     r[s] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) r[s] <= RST_VAL;
        else     r[s] <= r[s-1];
      end
    end
  end

  assign q = r[STAGES-1];
endmodule

// File: rtl/i2cw_phy.sv
module i2cw_phy
  import i2cw_pkg::*;
#(
  parameter int SETUP_CYC = 4,
  parameter int TMO_CYC = 2000
) (
  input  logic clk,
  input  logic rst,
  input  logic op_valid,
  input  op_e  op_kind,
  input  logic op_bit,
  input  logic scl_s,
  output logic op_ready,
  output logic op_done,
  output logic tmo_pulse,
  output logic scl_oe,
  output logic sda_oe
);
  localparam int MAXC = (TMO_CYC > SETUP_CYC) ? TMO_CYC : SETUP_CYC;
  localparam int CW = $clog2(MAXC + 1);
  localparam logic [CW-1:0] SETUP_LAST = CW'(SETUP_CYC - 1);
  localparam logic [CW-1:0] TMO_LAST = CW'(TMO_CYC - 1);

  typedef enum logic [2:0] {PH_IDLE, PH_SETUP, PH_RISE, PH_HIGH, PH_SDALO} ph_e;
  ph_e st;
  op_e kind_q;
  logic [CW-1:0] cnt;

  assign op_ready = (st == PH_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= PH_IDLE;
      kind_q <= OP_START;
      cnt <= '0;
      scl_oe <= 1'b0;
      sda_oe <= 1'b0;
      op_done <= 1'b0;
      tmo_pulse <= 1'b0;
    end else begin
      op_done <= 1'b0;
      tmo_pulse <= 1'b0;
      case (st)
        PH_IDLE: if (op_valid) begin
          kind_q <= op_kind;
          sda_oe <= (op_kind == OP_WR) ? ~op_bit : 1'b0;
          cnt <= '0;
          st <= PH_SETUP;
        end
        PH_SETUP: if (cnt == SETUP_LAST) begin
          scl_oe <= 1'b0;
          cnt <= '0;
          st <= PH_RISE;
        end else cnt <= cnt + 1'b1;
        PH_RISE: if (scl_s || cnt == TMO_LAST) begin
          tmo_pulse <= ~scl_s;
          cnt <= '0;
          if (kind_q == OP_HOLD) begin
            op_done <= 1'b1;
            st <= PH_IDLE;
          end else st <= PH_HIGH;
        end else cnt <= cnt + 1'b1;
        PH_HIGH: if (cnt == SETUP_LAST) begin
          cnt <= '0;
          if (kind_q == OP_START) begin
            sda_oe <= 1'b1;
            st <= PH_SDALO;
          end else begin
            scl_oe <= 1'b1;
            op_done <= 1'b1;
            st <= PH_IDLE;
          end
        end else cnt <= cnt + 1'b1;
        PH_SDALO: if (cnt == SETUP_LAST) begin
          scl_oe <= 1'b1;
          op_done <= 1'b1;
          cnt <= '0;
          st <= PH_IDLE;
        end else cnt <= cnt + 1'b1;
        default: st <= PH_IDLE;
      endcase
    end
  end

  AST_NO_STOP: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $fell(sda_oe)) |-> $past(scl_oe)); // R4
  AST_TMO_RELEASED: assert property (@(posedge clk) disable iff (rst)
    tmo_pulse |-> !scl_oe); // R8
endmodule

// File: rtl/i2cw_seq.sv
module i2cw_seq
  import i2cw_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_mode,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [BYTE_W-1:0] cmd_reg,
  input  logic [CNT_W-1:0]  cmd_bits,
  input  logic              bus_release,
  input  logic              phy_ready,
  input  logic              phy_done,
  input  logic              phy_tmo,
  input  logic              sda_s,
  input  logic              scl_s,
  output logic              op_valid,
  output op_e               op_kind,
  output logic              op_bit,
  output logic              busy,
  output logic              holding,
  output logic              err_range,
  output logic              stretch_to,
  output logic              held_sda,
  output logic              held_scl
);
  localparam logic [CNT_W-1:0] SLOT_LAST = CNT_W'(BYTE_W);

  typedef enum logic [3:0] {P_IDLE, P_S1, P_AW, P_RG, P_S2, P_AR, P_TL, P_HD, P_HOLDING} sq_e;
  sq_e ph, nxt;
  logic [1:0] mode_q;
  logic [ADDR_W-1:0] addr_q;
  logic [BYTE_W-1:0] reg_q, bsel;
  logic [CNT_W-1:0] bits_q, idx, limit;
  logic [2:0] bpos;
  logic pend, bad, last, ack_slot;

  assign busy = (ph != P_IDLE) && (ph != P_HOLDING);
  assign holding = (ph == P_HOLDING);
  assign op_valid = busy && !pend;
  assign ack_slot = (idx >= SLOT_LAST);
  assign bpos = 3'd7 - idx[2:0];
  assign op_bit = bsel[bpos];
  assign last = (idx == limit - 1'b1);
  assign bad = (cmd_mode == 2'd3) ||
               (cmd_mode == MODE_WRITE && cmd_bits > CNT_W'(BYTE_W)) ||
               (cmd_mode == MODE_READ && cmd_bits > CNT_W'(BYTE_W + 1));

  always_comb begin
    limit = CNT_W'(1);
    case (ph)
      P_AW: limit = (mode_q == MODE_ACK) ? CNT_W'(BYTE_W) : CNT_W'(BYTE_W + 1);
      P_RG, P_AR: limit = CNT_W'(BYTE_W + 1);
      P_TL: limit = bits_q;
      default: limit = CNT_W'(1);
    endcase
  end

  always_comb begin
    case (ph)
      P_S1: nxt = P_AW;
      P_AW:
        if (mode_q == MODE_ACK) nxt = P_HD;
        else if (mode_q == MODE_WRITE) nxt = (bits_q != '0) ? P_TL : P_HD;
        else nxt = P_RG;
      P_RG: nxt = P_S2;
      P_S2: nxt = P_AR;
      P_AR: nxt = (bits_q != '0) ? P_TL : P_HD;
      default: nxt = P_HD;
    endcase
  end

  always_comb begin
    op_kind = OP_START;
    bsel = reg_q;
    case (ph)
      P_AW: begin
        bsel = {addr_q, 1'b0};
        op_kind = ack_slot ? OP_RD : OP_WR;
      end
      P_RG: op_kind = ack_slot ? OP_RD : OP_WR;
      P_AR: begin
        bsel = {addr_q, 1'b1};
        op_kind = ack_slot ? OP_RD : OP_WR;
      end
      P_TL: op_kind = (mode_q == MODE_READ) ? OP_RD : OP_WR;
      P_HD: op_kind = OP_HOLD;
      default: op_kind = OP_START;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph <= P_IDLE;
      mode_q <= MODE_ACK;
      addr_q <= '0;
      reg_q <= '0;
      bits_q <= '0;
      idx <= '0;
      pend <= 1'b0;
      err_range <= 1'b0;
      stretch_to <= 1'b0;
      held_sda <= 1'b1;
      held_scl <= 1'b1;
    end else begin
      if (op_valid && phy_ready) pend <= 1'b1;
      if (phy_tmo) stretch_to <= 1'b1;
      case (ph)
        P_IDLE: if (cmd_valid) begin
          if (bad) err_range <= 1'b1;
          else begin
            err_range <= 1'b0;
            stretch_to <= 1'b0;
            mode_q <= cmd_mode;
            addr_q <= cmd_addr;
            reg_q <= cmd_reg;
            bits_q <= cmd_bits;
            idx <= '0;
            pend <= 1'b0;
            ph <= P_S1;
          end
        end
        P_HOLDING: if (bus_release) ph <= P_IDLE;
        default: if (phy_done) begin
          pend <= 1'b0;
          if (ph == P_HD) begin
            ph <= P_HOLDING;
            held_sda <= sda_s;
            held_scl <= scl_s;
          end else if (last) begin
            ph <= nxt;
            idx <= '0;
          end else idx <= idx + 1'b1;
        end
      endcase
    end
  end

  AST_TAIL_LIMIT: assert property (@(posedge clk) disable iff (rst)
    (ph == P_TL) |-> (idx < bits_q)); // R2
  AST_HELD_STABLE: assert property (@(posedge clk) disable iff (rst)
    (holding && $past(holding)) |-> ($stable(held_sda) && $stable(held_scl))); // R5
  AST_ERR_IDLE: assert property (@(posedge clk) disable iff (rst)
    err_range |-> !busy); // R6
endmodule

// File: rtl/i2c_wedge_injector.sv
module i2c_wedge_injector
  import i2cw_pkg::*;
#(
  parameter int SETUP_CYC = 4,
  parameter int TMO_CYC = 2000,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_mode,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [BYTE_W-1:0] cmd_reg,
  input  logic [CNT_W-1:0]  cmd_bits,
  input  logic              bus_release,
  input  logic              scl_in,
  input  logic              sda_in,
  output logic              scl_oe,
  output logic              sda_oe,
  output logic              busy,
  output logic              holding,
  output logic              err_range,
  output logic              stretch_to,
  output logic              held_sda,
  output logic              held_scl
);
  logic [1:0] lines_s;
  logic op_valid, op_bit, op_ready, op_done, tmo_pulse;
  op_e op_kind;

  i2cw_sync #(.WIDTH(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b11)) u_sync (
    .clk(clk), .rst(rst), .d({scl_in, sda_in}), .q(lines_s)
  );

  i2cw_seq u_seq (
    .clk(clk), .rst(rst),
    .cmd_valid(cmd_valid), .cmd_mode(cmd_mode), .cmd_addr(cmd_addr),
    .cmd_reg(cmd_reg), .cmd_bits(cmd_bits), .bus_release(bus_release),
    .phy_ready(op_ready), .phy_done(op_done), .phy_tmo(tmo_pulse),
    .sda_s(lines_s[0]), .scl_s(lines_s[1]),
    .op_valid(op_valid), .op_kind(op_kind), .op_bit(op_bit),
    .busy(busy), .holding(holding), .err_range(err_range),
    .stretch_to(stretch_to), .held_sda(held_sda), .held_scl(held_scl)
  );

  i2cw_phy #(.SETUP_CYC(SETUP_CYC), .TMO_CYC(TMO_CYC)) u_phy (
    .clk(clk), .rst(rst),
    .op_valid(op_valid), .op_kind(op_kind), .op_bit(op_bit),
    .scl_s(lines_s[1]), .op_ready(op_ready), .op_done(op_done),
    .tmo_pulse(tmo_pulse), .scl_oe(scl_oe), .sda_oe(sda_oe)
  );

  AST_HOLD_RELEASED: assert property (@(posedge clk) disable iff (rst)
    holding |-> (!scl_oe && !sda_oe)); // R4
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    (!busy && !holding) |-> (!scl_oe && !sda_oe)); // R6
  AST_HOLD_LEAVE: assert property (@(posedge clk) disable iff (rst)
    $fell(holding) |-> $past(bus_release)); // R7
endmodule

// File: tb/i2c_wedge_injector_test.sv
module i2c_wedge_injector_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cmd_valid = 1'b0;
  logic [1:0] cmd_mode = 2'd0;
  logic [6:0] cmd_addr = 7'd0;
  logic [7:0] cmd_reg = 8'd0;
  logic [3:0] cmd_bits = 4'd0;
  logic bus_release = 1'b0;
  logic stretch = 1'b0;
  logic sda_pull = 1'b0;
  logic scl_oe, sda_oe, busy, holding, err_range, stretch_to, held_sda, held_scl;
  logic scl_w, sda_w;

  int errs = 0;
  int checks = 0;
  int events = 0;
  int rises = 0;
  int cyc = 0;
  int exp_q[$];
  logic p_scl = 1'b1;
  logic p_sda = 1'b1;

  assign scl_w = ~(scl_oe | stretch);
  assign sda_w = ~(sda_oe | sda_pull);

  always #5 clk = ~clk;

  i2c_wedge_injector #(.SETUP_CYC(3), .TMO_CYC(40), .SYNC_STAGES(2)) uut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_mode(cmd_mode),
    .cmd_addr(cmd_addr), .cmd_reg(cmd_reg), .cmd_bits(cmd_bits),
    .bus_release(bus_release), .scl_in(scl_w), .sda_in(sda_w),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .busy(busy), .holding(holding),
    .err_range(err_range), .stretch_to(stretch_to),
    .held_sda(held_sda), .held_scl(held_scl)
  );

  task automatic check(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  // Monitor: token 0/1 = SDA at an SCL rise, 2 = start, 3 = stop
  task automatic bus_event(input int tok);
    events++;
    if (exp_q.size() == 0) check(1'b0, "R1/R2/R3 unexpected bus event", tok, -1);
    else begin
      int e;
      e = exp_q.pop_front();
      check(tok == e, "R1/R2/R3 bus token", tok, e);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (!rst) begin
      if (!p_scl && scl_w) begin
        rises++;
        bus_event(int'(sda_w));
      end else if (p_scl && scl_w && p_sda && !sda_w) bus_event(2);
      else if (p_scl && scl_w && !p_sda && sda_w) bus_event(3);
    end
    p_scl = scl_w;
    p_sda = sda_w;
    if (cyc > 150000) begin
      errs++;
      $display("FAIL R4 watchdog expired actual=%0d expected=%0d", cyc, 150000);
      finish_run();
    end
  end

  task automatic push_bits(input logic [7:0] b, input int n);
    for (int i = 0; i < n; i++) exp_q.push_back(int'(b[7-i]));
  endtask

  task automatic send_cmd(input logic [1:0] m, input logic [6:0] a, input logic [7:0] r, input logic [3:0] n);
    @(posedge clk); #1;
    cmd_valid = 1'b1; cmd_mode = m; cmd_addr = a; cmd_reg = r; cmd_bits = n;
    @(posedge clk); #1;
    cmd_valid = 1'b0;
  endtask

  task automatic wait_hold(input string req);
    int k;
    k = 0;
    while (!holding && k < 20000) begin
      @(negedge clk);
      k++;
    end
    check(holding == 1'b1, req, int'(holding), 1);
  endtask

  task automatic do_release();
    @(posedge clk); #1;
    bus_release = 1'b1;
    @(posedge clk); #1;
    bus_release = 1'b0;
    check(holding == 1'b0 && busy == 1'b0, "R7 release to idle", int'(holding), 0);
    check(scl_oe == 1'b0 && sda_oe == 1'b0, "R7 lines released after release", int'({scl_oe, sda_oe}), 0);
  endtask

  task automatic hold_checks(input string req);
    check(scl_oe == 1'b0 && sda_oe == 1'b0, "R4 hold lines released", int'({scl_oe, sda_oe}), 0);
    check(held_sda == 1'b1 && held_scl == 1'b1, "R5 held levels", int'({held_scl, held_sda}), 3);
    check(stretch_to == 1'b0, "R8 no timeout", int'(stretch_to), 0);
    check(exp_q.size() == 0, req, exp_q.size(), 0);
  endtask

  task automatic run_ack(input logic [6:0] a);
    exp_q.push_back(2);
    push_bits({a, 1'b0}, 8);
    exp_q.push_back(1);
    send_cmd(2'd0, a, 8'h00, 4'd0);
    wait_hold("R1 ack wedge reaches hold");
    hold_checks("R1 ack wedge token count");
  endtask

  task automatic run_write(input logic [6:0] a, input logic [7:0] r, input int n, input string req);
    exp_q.push_back(2);
    push_bits({a, 1'b0}, 8);
    exp_q.push_back(1);
    push_bits(r, n);
    exp_q.push_back(1);
    send_cmd(2'd2, a, r, 4'(n));
    wait_hold(req);
    hold_checks(req);
  endtask

  task automatic run_read(input logic [6:0] a, input logic [7:0] r, input int n, input string req);
    exp_q.push_back(2);
    push_bits({a, 1'b0}, 8);
    exp_q.push_back(1);
    push_bits(r, 8);
    exp_q.push_back(1);
    exp_q.push_back(1);
    exp_q.push_back(2);
    push_bits({a, 1'b1}, 8);
    exp_q.push_back(1);
    for (int i = 0; i < n; i++) exp_q.push_back(1);
    exp_q.push_back(1);
    send_cmd(2'd1, a, r, 4'(n));
    wait_hold(req);
    hold_checks(req);
  endtask

  task automatic run_bad(input logic [1:0] m, input logic [3:0] n);
    int ev0;
    ev0 = events;
    send_cmd(m, 7'h33, 8'hFF, n);
    repeat (30) @(negedge clk);
    check(err_range == 1'b1, "R6 err flag on bad command", int'(err_range), 1);
    check(busy == 1'b0 && holding == 1'b0, "R6 stays idle", int'({busy, holding}), 0);
    check(events == ev0, "R6 no bus activity", events - ev0, 0);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    check(scl_oe == 1'b0 && sda_oe == 1'b0, "R4 reset lines released", int'({scl_oe, sda_oe}), 0);
    check(busy == 1'b0 && holding == 1'b0 && err_range == 1'b0, "R6 reset idle", int'({busy, holding, err_range}), 0);

    run_ack(7'h50);
    begin : ignore_while_hold
      int ev0;
      ev0 = events;
      send_cmd(2'd2, 7'h0F, 8'hAA, 4'd3);
      repeat (60) @(negedge clk);
      check(holding == 1'b1, "R7 still holding after command", int'(holding), 1);
      check(events == ev0, "R7 command ignored in hold", events - ev0, 0);
      check(held_sda == 1'b1 && held_scl == 1'b1, "R5 held levels stable", int'({held_scl, held_sda}), 3);
    end
    do_release();

    run_write(7'h2C, 8'hA5, 5, "R2 write wedge 5 bits");
    do_release();
    run_write(7'h41, 8'h3C, 8, "R2 write wedge 8 bits");
    do_release();
    run_write(7'h7F, 8'h81, 0, "R9 write wedge zero bits");
    do_release();
    run_read(7'h11, 8'h80, 9, "R3 read wedge 9 bits");
    do_release();
    run_read(7'h6A, 8'h5E, 3, "R3 read wedge 3 bits");
    do_release();
    run_read(7'h02, 8'hC3, 0, "R9 read wedge zero bits");
    do_release();

    run_bad(2'd2, 4'd9);
    run_bad(2'd1, 4'd10);
    run_bad(2'd3, 4'd0);
    run_ack(7'h15);
    check(err_range == 1'b0, "R6 err cleared by accepted command", int'(err_range), 0);
    do_release();

    begin : stretch_timeout
      int base;
      int k;
      base = rises;
      exp_q.push_back(2);
      push_bits({7'h39, 1'b0}, 8);
      exp_q.push_back(1);
      send_cmd(2'd0, 7'h39, 8'h00, 4'd0);
      k = 0;
      while (!(rises == base + 8 && scl_oe == 1'b1) && k < 20000) begin
        @(negedge clk);
        k++;
      end
      stretch = 1'b1;
      sda_pull = 1'b1;
      wait_hold("R8 hold entered after timeout");
      check(stretch_to == 1'b1, "R8 timeout flag", int'(stretch_to), 1);
      check(scl_oe == 1'b0 && sda_oe == 1'b0, "R8 lines released on timeout", int'({scl_oe, sda_oe}), 0);
      check(held_scl == 1'b0 && held_sda == 1'b0, "R5 held levels under stretch", int'({held_scl, held_sda}), 0);
      sda_pull = 1'b0;
      repeat (2) @(negedge clk);
      stretch = 1'b0;
      repeat (4) @(negedge clk);
      check(exp_q.size() == 0, "R1 tokens under stretch", exp_q.size(), 0);
      do_release();
    end

    run_ack(7'h66);
    check(stretch_to == 1'b0, "R8 timeout flag cleared by new command", int'(stretch_to), 0);
    do_release();

    repeat (10) @(negedge clk);
    finish_run();
  end
endmodule